// File: doc/BRIEF.md
# Paged Control-Register Access Engine

This block lets a simple requester read and write registers of a serial-link PHY. The PHY registers are not mapped directly onto the system bus. Instead, they sit behind two layers of indirection.

The outer layer is a 512-word bus window. Before each access to the window, a page-select word is written at bus offset 0x800. That word carries the device number and the upper bits of the PHY register address. The window word is then reached at an offset taken from the lower address bits.

The inner layer is a three-register control port inside the PHY: control, address and data. To access a PHY register, the engine waits for the port to report idle, posts the address (and the data, for a write), and then issues a start command with a direction flag. A read also waits for the port to go idle again before it fetches the result.

The requester sees a valid/ready request channel and a one-cycle response pulse that carries read data. While the port reports busy, the engine polls it at a fixed, parameterised spacing.

Top module: `cr_paged_engine`

## Requirements
- R1: After reset, `req_ready` is 1, and both `bus_req` and `rsp_valid` are 0.
- R2: Every access to the control port is a pair of bus accesses that nothing else interleaves:
  - first, a write to bus offset 0x800 whose low 12 bits are `{dev[4:0], reg_addr[15:9]}`;
  - then the access itself at bus offset `{1'b0, reg_addr[8:0], 2'b00}`.
- R3: Once `bus_req` is raised, it stays high until `bus_ack` is sampled. Until then, `bus_addr`, `bus_we` and `bus_wdata` hold their values.
- R4: A write request produces the following control-port accesses, in this order:
  1. reads of the control register at 0x80A1-1 (0x80A0) until bit 0 (busy) reads 0;
  2. a write of the target address to 0x80A1;
  3. a write of the data to 0x80A2;
  4. a write of 0x0003 to 0x80A0, where bit 0 means start and bit 1 means write.

  After that, `req_ready` returns without polling again.
- R5: A read request produces the following control-port accesses, in this order:
  1. polls of 0x80A0 until it is not busy;
  2. a write of the address to 0x80A1;
  3. a write of 0x0001 to 0x80A0;
  4. polls of 0x80A0 until it is not busy;
  5. a read of 0x80A2.

  The engine then raises `rsp_valid` for exactly one cycle, with `rsp_rdata` equal to the low DATA_W bits of the returned word.
- R6: After a poll that reads busy, the next bus access starts no fewer than POLL_GAP cycles later.
- R7: While `req_ready` is 0, a request presented on `req_valid` is neither accepted nor executed, and it leaves the PHY registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | PHY device number |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data |
| bus_req | output | 1 | Bus access pending |
| bus_we | output | 1 | Bus access direction |
| bus_addr | output | 12 | Bus byte offset in the window |
| bus_wdata | output | BUS_DW | Bus write data |
| bus_ack | input | 1 | Bus access completes this cycle |
| bus_rdata | input | BUS_DW | Bus read data, valid with bus_ack |

## Verification
A wrong page or window state shows on the very next bus access: an offset or device field decodes to the wrong PHY register, or a data access arrives without a fresh page word in front of it. A sequencing fault shows on the bus within one control-port access, as a post, start or fetch issued while the port still reports busy. A timing fault shows within one poll spacing, as a poll that comes too early. A lost or wrong latched request shows later, at the port: as corrupted read data, as a missing response pulse, or when a later read returns a value that an ignored request should not have written.

// File: rtl/cr_paged_pkg.sv
package cr_paged_pkg;

  localparam int PG_DEV_W = 5;
  localparam int PG_HI_W  = 7;
  localparam int WIN_W    = 9;
  localparam int REG_AW   = PG_HI_W + WIN_W;
  localparam int SEL_W    = PG_DEV_W + PG_HI_W;
  localparam int BUS_AW   = WIN_W + 3;

  localparam logic [BUS_AW-1:0] SEL_OFFSET = BUS_AW'(12'h800);

  localparam logic [REG_AW-1:0] CR_CTL = 16'h80A0;
  localparam logic [REG_AW-1:0] CR_ADR = 16'h80A1;
  localparam logic [REG_AW-1:0] CR_DAT = 16'h80A2;

  localparam int CTL_BUSY_BIT = 0;

  typedef enum logic [1:0] {WP_IDLE, WP_SEL, WP_ACC} win_state_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_POLL, SQ_PACE, SQ_ADDR, SQ_DATA, SQ_KICK, SQ_FETCH
  } seq_state_t;

  // Page-select word: device number above the upper register-address bits.
  function automatic logic [SEL_W-1:0] page_word(input logic [PG_DEV_W-1:0] dev,
                                                 input logic [REG_AW-1:0] ra);
    return {dev, ra[REG_AW-1:WIN_W]};
  endfunction

  // Byte offset of the word inside the window.
  function automatic logic [BUS_AW-1:0] win_offset(input logic [REG_AW-1:0] ra);
    return {1'b0, ra[WIN_W-1:0], 2'b00};
  endfunction

  // Start command: bit 0 starts the access, bit 1 marks it as a write.
  function automatic logic [1:0] kick_word(input logic is_write);
    return {is_write, 1'b1};
  endfunction

endpackage

// File: rtl/cr_win_port.sv
module cr_win_port
  import cr_paged_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic                op_we,
  input  logic [PG_DEV_W-1:0] op_dev,
  input  logic [REG_AW-1:0]   op_reg,
  input  logic [DATA_W-1:0]   op_wdata,
  output logic                op_done,
  output logic [DATA_W-1:0]   op_rdata,
  output logic                bus_req,
  output logic                bus_we,
  output logic [BUS_AW-1:0]   bus_addr,
  output logic [BUS_DW-1:0]   bus_wdata,
  input  logic                bus_ack,
  input  logic [BUS_DW-1:0]   bus_rdata
);

  win_state_t          st;
  logic                r_we;
  logic [PG_DEV_W-1:0] r_dev;
  logic [REG_AW-1:0]   r_reg;
  logic [DATA_W-1:0]   r_wdata;

  logic sel_done;
  logic acc_done;

  assign sel_done = (st == WP_SEL) && bus_ack;
  assign acc_done = (st == WP_ACC) && bus_ack;
  assign op_done  = acc_done;
  assign op_rdata = bus_rdata[DATA_W-1:0];

  assign bus_req = (st != WP_IDLE);

  always_comb begin
    if (st == WP_SEL) begin
      bus_we    = 1'b1;
      bus_addr  = SEL_OFFSET;
      bus_wdata = BUS_DW'(page_word(r_dev, r_reg));
    end else begin
      bus_we    = r_we;
      bus_addr  = win_offset(r_reg);
      bus_wdata = BUS_DW'(r_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WP_IDLE;
      r_we    <= 1'b0;
      r_dev   <= '0;
      r_reg   <= '0;
      r_wdata <= '0;
    end else begin
      case (st)
        WP_IDLE: if (op_valid) begin
          r_we    <= op_we;
          r_dev   <= op_dev;
          r_reg   <= op_reg;
          r_wdata <= op_wdata;
          st      <= WP_SEL;
        end
        WP_SEL:  if (sel_done) st <= WP_ACC;
        WP_ACC:  if (acc_done) st <= WP_IDLE;
        default: st <= WP_IDLE;
      endcase
    end
  end

  // Tracks whether a page word is outstanding for the next data access.
  logic sel_fresh;
  always_ff @(posedge clk) begin
    if (!rst_n) sel_fresh <= 1'b0;
    else if (sel_done) sel_fresh <= 1'b1;
    else if (acc_done) sel_fresh <= 1'b0;
  end

  // R2
  page_before_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> sel_fresh);

  // R2
  access_follows_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> bus_req && (bus_addr != SEL_OFFSET));

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                              && $stable(bus_wdata));

endmodule

// File: rtl/cr_poll_pacer.sv
module cr_poll_pacer #(
  parameter int POLL_GAP = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = $clog2(POLL_GAP + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CW'(POLL_GAP);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/cr_seq.sv
module cr_seq
  import cr_paged_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_GAP = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [PG_DEV_W-1:0] req_dev,
  input  logic [REG_AW-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                op_valid,
  output logic                op_we,
  output logic [PG_DEV_W-1:0] op_dev,
  output logic [REG_AW-1:0]   op_reg,
  output logic [DATA_W-1:0]   op_wdata,
  input  logic                op_done,
  input  logic [DATA_W-1:0]   op_rdata,
  output logic                pace_load,
  input  logic                pace_expired
);

  seq_state_t          st;
  logic                inflight;
  logic                second;
  logic                r_we;
  logic [PG_DEV_W-1:0] r_dev;
  logic [REG_AW-1:0]   r_addr;
  logic [DATA_W-1:0]   r_wdata;

  logic accept;
  logic op_state;
  logic poll_busy;
  logic poll_clear;
  logic poll_issue;
  logic kick_issue;
  logic fetch_issue;

  assign req_ready = (st == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign op_state  = (st == SQ_POLL) || (st == SQ_ADDR) || (st == SQ_DATA)
                   || (st == SQ_KICK) || (st == SQ_FETCH);
  assign op_valid  = op_state && !inflight;
  assign op_dev    = r_dev;

  assign poll_busy   = (st == SQ_POLL) && op_done && op_rdata[CTL_BUSY_BIT];
  assign poll_clear  = (st == SQ_POLL) && op_done && !op_rdata[CTL_BUSY_BIT];
  assign poll_issue  = (st == SQ_POLL) && op_valid;
  assign kick_issue  = (st == SQ_KICK) && op_valid;
  assign fetch_issue = (st == SQ_FETCH) && op_valid;
  assign pace_load   = poll_busy;

  always_comb begin
    op_we    = 1'b0;
    op_reg   = CR_CTL;
    op_wdata = '0;
    case (st)
      SQ_ADDR: begin
        op_we    = 1'b1;
        op_reg   = CR_ADR;
        op_wdata = DATA_W'(r_addr);
      end
      SQ_DATA: begin
        op_we    = 1'b1;
        op_reg   = CR_DAT;
        op_wdata = r_wdata;
      end
      SQ_KICK: begin
        op_we    = 1'b1;
        op_reg   = CR_CTL;
        op_wdata = DATA_W'(kick_word(r_we));
      end
      SQ_FETCH: op_reg = CR_DAT;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      inflight  <= 1'b0;
      second    <= 1'b0;
      r_we      <= 1'b0;
      r_dev     <= '0;
      r_addr    <= '0;
      r_wdata   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (op_valid)     inflight <= 1'b1;
      else if (op_done) inflight <= 1'b0;
      case (st)
        SQ_IDLE: if (accept) begin
          r_we    <= req_we;
          r_dev   <= req_dev;
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          second  <= 1'b0;
          st      <= SQ_POLL;
        end
        SQ_POLL: begin
          if (poll_busy)       st <= SQ_PACE;
          else if (poll_clear) st <= second ? SQ_FETCH : SQ_ADDR;
        end
        SQ_PACE: if (pace_expired) st <= SQ_POLL;
        SQ_ADDR: if (op_done) st <= r_we ? SQ_DATA : SQ_KICK;
        SQ_DATA: if (op_done) st <= SQ_KICK;
        SQ_KICK: if (op_done) begin
          if (r_we) st <= SQ_IDLE;
          else begin
            second <= 1'b1;
            st     <= SQ_POLL;
          end
        end
        SQ_FETCH: if (op_done) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= op_rdata;
          st        <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // Checker state: last poll outcome and spacing since a busy reading.
  localparam int GW = $clog2(POLL_GAP + 2) + 1;
  logic          clear_seen;
  logic          after_busy;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clear_seen <= 1'b0;
      after_busy <= 1'b0;
      gap_cnt    <= '0;
    end else begin
      if (poll_clear) clear_seen <= 1'b1;
      else if (kick_issue || fetch_issue) clear_seen <= 1'b0;
      if (poll_busy) begin
        after_busy <= 1'b1;
        gap_cnt    <= '0;
      end else begin
        if (poll_issue) after_busy <= 1'b0;
        if (gap_cnt != {GW{1'b1}}) gap_cnt <= gap_cnt + 1'b1;
      end
    end
  end

  // R4
  kick_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_issue |-> clear_seen);

  // R5
  fetch_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_issue |-> clear_seen && second);

  // R6
  poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_issue && after_busy) |-> (gap_cnt >= GW'(POLL_GAP)));

  // R7
  ignore_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(r_addr) && $stable(r_wdata) && $stable(r_we)
                   && $stable(r_dev));

endmodule

// File: rtl/cr_paged_engine.sv
module cr_paged_engine
  import cr_paged_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BUS_DW   = 32,
  parameter int POLL_GAP = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [PG_DEV_W-1:0] req_dev,
  input  logic [REG_AW-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_req,
  output logic                bus_we,
  output logic [BUS_AW-1:0]   bus_addr,
  output logic [BUS_DW-1:0]   bus_wdata,
  input  logic                bus_ack,
  input  logic [BUS_DW-1:0]   bus_rdata
);

  logic                op_valid;
  logic                op_we;
  logic [PG_DEV_W-1:0] op_dev;
  logic [REG_AW-1:0]   op_reg;
  logic [DATA_W-1:0]   op_wdata;
  logic                op_done;
  logic [DATA_W-1:0]   op_rdata;
  logic                pace_load;
  logic                pace_expired;

  cr_seq #(.DATA_W(DATA_W), .POLL_GAP(POLL_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .op_valid(op_valid), .op_we(op_we), .op_dev(op_dev), .op_reg(op_reg),
    .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
    .pace_load(pace_load), .pace_expired(pace_expired)
  );

  cr_poll_pacer #(.POLL_GAP(POLL_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(pace_load), .expired(pace_expired)
  );

  cr_win_port #(.DATA_W(DATA_W), .BUS_DW(BUS_DW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_we(op_we), .op_dev(op_dev), .op_reg(op_reg),
    .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

endmodule

// File: tb/tb_cr_paged_engine.sv
module tb_cr_paged_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int BUS_DW     = 32;
  localparam int POLL_GAP   = 6;
  localparam logic [15:0] A_CTL = 16'h80A0;
  localparam logic [15:0] A_ADR = 16'h80A1;
  localparam logic [15:0] A_DAT = 16'h80A2;

  logic clk, rst_n;
  logic req_valid, req_ready, req_we;
  logic [4:0] req_dev;
  logic [15:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic bus_req, bus_we, bus_ack;
  logic [11:0] bus_addr;
  logic [BUS_DW-1:0] bus_wdata, bus_rdata;

  cr_paged_engine #(.DATA_W(DATA_W), .BUS_DW(BUS_DW), .POLL_GAP(POLL_GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int n_checks = 0;
  int n_fail = 0;

  // PHY-side model state
  logic [11:0] pg;
  bit          pg_ok = 0;
  int          busy_left = 0;
  int          last_kick_busy = 0;
  int          force_busy = -1;
  logic [15:0] cr_a, cr_d;
  logic [15:0] phy_mem [256];
  logic [15:0] exp_mem [256];
  logic [4:0]  cur_dev = '0;
  logic [32:0] lg [128];
  int          n_lg = 0;
  logic [32:0] ex [128];
  int          n_ex = 0;
  int          cyc = 0;
  int          busy_ack_cyc = 0;
  bit          after_busy = 0;
  int          wait_left = -1;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 257) ^ 16'h5A5A;
  endfunction

  task automatic cr_op(input logic [15:0] ra, input logic we, input logic [15:0] d);
    logic [31:0] junk;
    if (n_lg < 128) begin
      lg[n_lg] = {we, ra, we ? d : 16'h0};
      n_lg++;
    end
    junk = $urandom;
    if (ra == A_CTL) begin
      if (!we) begin
        junk[0] = (busy_left > 0);
        bus_rdata = junk;
        if (busy_left > 0) begin
          busy_left--;
          after_busy = 1;
          busy_ack_cyc = cyc;
        end
      end else begin
        chk(busy_left == 0, "R4 start issued only when idle", 64'(busy_left), 0);
        if (d[1]) phy_mem[cr_a[7:0]] = cr_d;
        else      cr_d = phy_mem[cr_a[7:0]];
        last_kick_busy = (force_busy >= 0) ? force_busy : int'($urandom % 4);
        busy_left = last_kick_busy;
      end
    end else if (ra == A_ADR) begin
      chk(we && busy_left == 0, "R4 address posted when idle", 64'(busy_left), 0);
      cr_a = d;
    end else if (ra == A_DAT) begin
      if (we) cr_d = d;
      else bus_rdata = {junk[31:16], cr_d};
    end else begin
      chk(0, "R2 register outside control port", 64'(ra), 64'(A_CTL));
    end
  endtask

  task automatic serve();
    logic [15:0] ra;
    if (bus_we && bus_addr == 12'h800) begin
      pg = bus_wdata[11:0];
      pg_ok = 1;
      bus_rdata = '0;
    end else begin
      chk(pg_ok, "R2 page word precedes access", 64'(pg_ok), 1);
      pg_ok = 0;
      chk(bus_addr[1:0] == 2'b00 && !bus_addr[11], "R2 window offset form",
          64'(bus_addr), 64'({1'b0, bus_addr[10:2], 2'b00}));
      chk(pg[11:7] == cur_dev, "R2 device field", 64'(pg[11:7]), 64'(cur_dev));
      ra = {pg[6:0], bus_addr[10:2]};
      cr_op(ra, bus_we, bus_wdata[15:0]);
    end
  endtask

  // Bus responder with random latency
  initial begin
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (bus_ack) begin
        bus_ack = 1'b0;
        wait_left = -1;
      end else if (bus_req) begin
        if (after_busy) begin
          chk(cyc - busy_ack_cyc >= POLL_GAP, "R6 poll spacing after busy",
              64'(cyc - busy_ack_cyc), 64'(POLL_GAP));
          after_busy = 0;
        end
        if (wait_left < 0) wait_left = int'($urandom % 3);
        if (wait_left == 0) begin
          serve();
          bus_ack = 1'b1;
          wait_left = -1;
        end else wait_left--;
      end
    end
  end

  task automatic add_ex(input logic we, input logic [15:0] ra, input logic [15:0] d);
    if (n_ex < 128) begin
      ex[n_ex] = {we, ra, d};
      n_ex++;
    end
  endtask

  task automatic cmp_log(input string tag);
    bit same;
    same = (n_lg == n_ex);
    for (int i = 0; i < n_ex && same; i++) if (lg[i] != ex[i]) same = 0;
    chk(same, tag, 64'(n_lg), 64'(n_ex));
  endtask

  task automatic do_op(input bit we, input logic [4:0] dev, input logic [15:0] addr,
                       input logic [15:0] data, input bit poke);
    int pre;
    while (!req_ready) @(negedge clk);
    cur_dev = dev;
    n_lg = 0;
    n_ex = 0;
    pre = busy_left;
    req_valid = 1'b1; req_we = we; req_dev = dev; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R7 ready drops after acceptance", 64'(req_ready), 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!req_ready, "R7 still busy at stray request", 64'(req_ready), 0);
      req_valid = 1'b1; req_we = 1'b1; req_addr = addr ^ 16'h0001; req_wdata = 16'hFFFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i <= pre; i++) add_ex(1'b0, A_CTL, 16'h0);
    add_ex(1'b1, A_ADR, addr);
    if (we) begin
      add_ex(1'b1, A_DAT, data);
      add_ex(1'b1, A_CTL, 16'h0003);
      while (!req_ready) @(negedge clk);
      chk(busy_left == last_kick_busy, "R4 no wait after start",
          64'(busy_left), 64'(last_kick_busy));
      exp_mem[addr[7:0]] = data;
      cmp_log("R4 write access order");
    end else begin
      while (!rsp_valid) @(negedge clk);
      chk(rsp_rdata == exp_mem[addr[7:0]], "R5 read data",
          64'(rsp_rdata), 64'(exp_mem[addr[7:0]]));
      add_ex(1'b1, A_CTL, 16'h0001);
      for (int i = 0; i <= last_kick_busy; i++) add_ex(1'b0, A_CTL, 16'h0);
      add_ex(1'b0, A_DAT, 16'h0);
      cmp_log("R5 read access order");
      @(negedge clk);
      chk(!rsp_valid, "R5 response is one cycle", 64'(rsp_valid), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      phy_mem[i] = init_word(i);
      exp_mem[i] = init_word(i);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_dev = '0;
    req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
    chk(bus_req == 1'b0, "R1 bus idle after reset", 64'(bus_req), 0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 0);

    // Directed corners: extreme devices and addresses
    do_op(1'b1, 5'd0,  16'h0000, 16'h1234, 1'b0);
    do_op(1'b0, 5'd0,  16'h0000, 16'h0, 1'b0);
    do_op(1'b1, 5'd31, 16'hFFFF, 16'hBEEF, 1'b0);
    do_op(1'b0, 5'd31, 16'hFFFF, 16'h0, 1'b0);
    // Long busy on both phases, with a stray request while busy (R7)
    force_busy = 5;
    busy_left = 4;
    do_op(1'b0, 5'd9, 16'h0120, 16'h0, 1'b1);
    force_busy = -1;
    do_op(1'b0, 5'd9, 16'h0121, 16'h0, 1'b0);
    // Random mix
    for (int n = 0; n < 40; n++) begin
      logic [15:0] a;
      a = 16'($urandom);
      a[7:4] = 4'h0;
      do_op(1'($urandom), 5'($urandom), a, 16'($urandom), 1'b0);
    end
    report();
    $finish;
  end

endmodule